// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor-side request port and a cache controller and keeps track of every cache line that has a request in flight. Each incoming request is sorted into a read class or a write class. It is then held in one of two small associative tables, keyed by line address, one table per class. In the same cycle the block answers with a two-bit status: the request was issued, it was refused because the line is already busy in either table, or it was refused because there is no room.

The controller frees entries with separate read and write completion strobes that carry the line address. A running outstanding count always equals the total occupancy of both tables. Four saturating-free stall counters record which kind of alias collision refused a request. An age watchdog runs only while work is outstanding. It flags a possible deadlock when any entry has been held for the configured threshold or longer. A completion that matches nothing raises a sticky protocol-error flag.

Top module: `line_req_tracker`

## Requirements
- R1: Request kind codes are LOAD=0 and IFETCH=1 (read class). STORE=2, RMW_RD=3, RMW_WR=4, LL=5, SC=6, LOCKED_RD=7, LOCKED_WR=8 and FLUSH=9 are write class, and so are all other codes. Read-class requests are held in the read table and write-class requests in the write table.
- R2: When `outstanding` is at or above MAX_OUT, a request gets status 2'b11 (full) before any alias lookup, and no stall counter changes.
- R3: A write-class request whose line is present in the read table gets status 2'b10 (aliased), and `stall_st_ld` increments.
- R4: A write-class request whose line is present only in the write table gets status 2'b10, and `stall_st_st` increments.
- R5: A read-class request whose line is in the write table gets 2'b10 and `stall_ld_st` increments. Otherwise, if its line is in the read table, it gets 2'b10 and `stall_ld_ld` increments.
- R6: A request that is not refused gets status 2'b01 (issued), and `outstanding` rises by one after the clock edge. Lines are compared with the low log2(LINE_BYTES) address bits ignored. With no request, the status is 2'b00.
- R7: A read or write completion for a line held in the matching table removes that entry and lowers `outstanding` by one. The line can then be issued again.
- R8: `outstanding` always equals the sum of both table occupancies. An accepted request and a completion in the same cycle leave it unchanged.
- R9: The watchdog arms on an accepted request when it is idle, and it fires WDOG_CYC cycles later. If any entry then has an age of at least WDOG_CYC, `deadlock` rises and stays high until reset. While requests remain outstanding, the watchdog rearms for another period.
- R10: Entries completed before reaching the threshold never raise `deadlock`. When the watchdog fires with nothing outstanding, it disarms.
- R11: A completion whose line is not in the table of its own class sets the sticky `proto_err` and changes no entry.
- R12: A request whose line is not aliased, but whose class table has no free slot, gets status 2'b11 even when `outstanding` is below MAX_OUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 4 | Request kind code |
| req_addr | input | ADDR_W | Request byte address |
| rsp_status | output | 2 | 00 none, 01 issued, 10 aliased, 11 full (same cycle) |
| rd_done | input | 1 | Read completion strobe |
| rd_done_addr | input | ADDR_W | Line address of read completion |
| wr_done | input | 1 | Write completion strobe |
| wr_done_addr | input | ADDR_W | Line address of write completion |
| outstanding | output | $clog2(MAX_OUT+1) | Entries held in both tables |
| stall_st_ld | output | CNT_W | Write refused by busy read line |
| stall_st_st | output | CNT_W | Write refused by busy write line |
| stall_ld_st | output | CNT_W | Read refused by busy write line |
| stall_ld_ld | output | CNT_W | Read refused by busy read line |
| deadlock | output | 1 | Sticky age-watchdog flag |
| proto_err | output | 1 | Sticky stray-completion flag |

## Verification
The classifier is exercised by mixing loads, fetches, stores, flushes, linked and locked kinds onto lines that are already busy. Each stall counter moves only for its own collision, and this separates the write-class kinds from the read-class kinds. Addresses that differ only in offset bits separate line comparison from full-address comparison. Requests sent while the tracker is at its count limit, or while only one table is full, separate the two refusal causes. The aliased line used at the count limit shows that the limit is checked before the lookup. The watchdog runs in three cases: an entry that stays too long, an entry that finishes early while a later one is caught on the rearmed period, and a tracker that goes idle.

// File: rtl/lrt_pkg.sv
package lrt_pkg;
  typedef enum logic [3:0] {
    K_LOAD      = 4'd0,
    K_IFETCH    = 4'd1,
    K_STORE     = 4'd2,
    K_RMW_RD    = 4'd3,
    K_RMW_WR    = 4'd4,
    K_LL        = 4'd5,
    K_SC        = 4'd6,
    K_LOCKED_RD = 4'd7,
    K_LOCKED_WR = 4'd8,
    K_FLUSH     = 4'd9
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_NONE   = 2'b00,
    ST_ISSUED = 2'b01,
    ST_ALIAS  = 2'b10,
    ST_FULL   = 2'b11
  } rsp_status_e;

  // only plain loads and instruction fetches are read class
  function automatic logic is_write_class(input logic [3:0] kind);
    return !((kind == K_LOAD) || (kind == K_IFETCH));
  endfunction
endpackage

// File: rtl/lrt_line_table.sv
module lrt_line_table #(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 26,
  parameter int AGE_W  = 10,
  parameter int THRESH = 100,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] look_tag,
  output logic             look_hit,
  output logic             full,
  input  logic             ins_en,
  input  logic [AGE_W-1:0] now,
  input  logic             del_en,
  input  logic [TAG_W-1:0] del_tag,
  output logic             del_hit,
  output logic [OCC_W-1:0] occ,
  output logic             any_old
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] valid;
  logic [TAG_W-1:0] tag   [DEPTH];
  logic [AGE_W-1:0] issue [DEPTH];
  logic [DEPTH-1:0] look_match, del_match, old_vec;
  logic [IDX_W-1:0] free_idx;

  function automatic logic [AGE_W-1:0] age_of(input logic [AGE_W-1:0] t_now,
                                               input logic [AGE_W-1:0] t_iss);
    return t_now - t_iss;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign look_match[i] = valid[i] && (tag[i] == look_tag);
    assign del_match[i]  = valid[i] && (tag[i] == del_tag);
    assign old_vec[i]    = valid[i] && (age_of(now, issue[i]) >= AGE_W'(THRESH));
  end

  assign look_hit = |look_match;
  assign del_hit  = |del_match;
  assign full     = &valid;
  assign any_old  = |old_vec;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    occ = '0;
    for (int i = 0; i < DEPTH; i++) occ = occ + OCC_W'(valid[i]);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid[i] <= 1'b0;
        tag[i]   <= '0;
        issue[i] <= '0;
      end else if (ins_en && !full && (free_idx == IDX_W'(i))) begin
        valid[i] <= 1'b1;
        tag[i]   <= look_tag;
        issue[i] <= now;
      end else if (del_en && del_match[i]) begin
        valid[i] <= 1'b0;
      end
    end
  end

  AST_INS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> !full) else $error("insert into full table"); // R12
  AST_DEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (del_en && del_hit && !ins_en) |=> (occ == $past(occ) - OCC_W'(1))) else $error("delete kept entry"); // R7
endmodule

// File: rtl/lrt_watchdog.sv
module lrt_watchdog #(
  parameter int WDOG_CYC = 1000,
  localparam int TMR_W = $clog2(WDOG_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_req,
  input  logic busy,
  input  logic any_old,
  output logic deadlock
);
  logic             armed;
  logic [TMR_W-1:0] timer;
  logic             fire;

  assign fire = armed && (timer == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      timer    <= '0;
      deadlock <= 1'b0;
    end else if (fire) begin
      if (any_old) deadlock <= 1'b1;
      if (busy || arm_req) timer <= TMR_W'(WDOG_CYC - 1);
      else armed <= 1'b0;
    end else if (armed) begin
      timer <= timer - TMR_W'(1);
    end else if (arm_req) begin
      armed <= 1'b1;
      timer <= TMR_W'(WDOG_CYC - 1);
    end
  end

  AST_IDLE_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !busy && !arm_req) |=> !armed) else $error("watchdog stayed armed"); // R10
  AST_DEADLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |=> deadlock) else $error("deadlock flag dropped"); // R9
  AST_OLD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && any_old) |=> deadlock) else $error("old entry missed"); // R9
endmodule

// File: rtl/line_req_tracker.sv
module line_req_tracker
  import lrt_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int RD_DEPTH   = 4,
  parameter int WR_DEPTH   = 4,
  parameter int MAX_OUT    = 6,
  parameter int WDOG_CYC   = 1000,
  parameter int CNT_W      = 16,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int TAG_W = ADDR_W - OFF_W,
  localparam int OUT_W = $clog2(MAX_OUT + 1),
  localparam int AGE_W = $clog2(WDOG_CYC + 1) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        rsp_status,
  input  logic              rd_done,
  input  logic [ADDR_W-1:0] rd_done_addr,
  input  logic              wr_done,
  input  logic [ADDR_W-1:0] wr_done_addr,
  output logic [OUT_W-1:0]  outstanding,
  output logic [CNT_W-1:0]  stall_st_ld,
  output logic [CNT_W-1:0]  stall_st_st,
  output logic [CNT_W-1:0]  stall_ld_st,
  output logic [CNT_W-1:0]  stall_ld_ld,
  output logic              deadlock,
  output logic              proto_err
);
  localparam int RD_OCC_W = $clog2(RD_DEPTH + 1);
  localparam int WR_OCC_W = $clog2(WR_DEPTH + 1);

  function automatic logic [TAG_W-1:0] line_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  logic [TAG_W-1:0]    req_tag;
  logic                wr_cls, rd_hit, wr_hit, rd_full, wr_full;
  logic                rd_del_hit, wr_del_hit, rd_old, wr_old;
  logic [RD_OCC_W-1:0] rd_occ;
  logic [WR_OCC_W-1:0] wr_occ;
  logic [AGE_W-1:0]    now;
  rsp_status_e         status;
  logic                accept, rd_ins, wr_ins, rd_free, wr_free;
  logic                count_full, tgt_full, stray;

  assign req_tag    = line_tag(req_addr);
  assign wr_cls     = is_write_class(req_kind);
  assign count_full = (int'(outstanding) >= MAX_OUT);
  assign tgt_full   = wr_cls ? wr_full : rd_full;

  always_comb begin
    if (!req_valid)                 status = ST_NONE;
    else if (count_full)            status = ST_FULL;
    else if (rd_hit || wr_hit)      status = ST_ALIAS;
    else if (tgt_full)              status = ST_FULL;
    else                            status = ST_ISSUED;
  end

  assign rsp_status = status;
  assign accept     = (status == ST_ISSUED);
  assign rd_ins     = accept && !wr_cls;
  assign wr_ins     = accept && wr_cls;
  assign rd_free    = rd_done && rd_del_hit;
  assign wr_free    = wr_done && wr_del_hit;
  assign stray      = (rd_done && !rd_del_hit) || (wr_done && !wr_del_hit);

  lrt_line_table #(.DEPTH(RD_DEPTH), .TAG_W(TAG_W), .AGE_W(AGE_W), .THRESH(WDOG_CYC)) u_rd_tab (
    .clk(clk), .rst_n(rst_n), .look_tag(req_tag), .look_hit(rd_hit), .full(rd_full),
    .ins_en(rd_ins), .now(now), .del_en(rd_done), .del_tag(line_tag(rd_done_addr)),
    .del_hit(rd_del_hit), .occ(rd_occ), .any_old(rd_old));

  lrt_line_table #(.DEPTH(WR_DEPTH), .TAG_W(TAG_W), .AGE_W(AGE_W), .THRESH(WDOG_CYC)) u_wr_tab (
    .clk(clk), .rst_n(rst_n), .look_tag(req_tag), .look_hit(wr_hit), .full(wr_full),
    .ins_en(wr_ins), .now(now), .del_en(wr_done), .del_tag(line_tag(wr_done_addr)),
    .del_hit(wr_del_hit), .occ(wr_occ), .any_old(wr_old));

  lrt_watchdog #(.WDOG_CYC(WDOG_CYC)) u_wdog (
    .clk(clk), .rst_n(rst_n), .arm_req(accept), .busy(outstanding != '0),
    .any_old(rd_old || wr_old), .deadlock(deadlock));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now         <= '0;
      outstanding <= '0;
      proto_err   <= 1'b0;
      stall_st_ld <= '0;
      stall_st_st <= '0;
      stall_ld_st <= '0;
      stall_ld_ld <= '0;
    end else begin
      now         <= now + AGE_W'(1);
      outstanding <= outstanding + OUT_W'(accept) - OUT_W'(rd_free) - OUT_W'(wr_free);
      if (stray) proto_err <= 1'b1;
      if (status == ST_ALIAS) begin
        if (wr_cls && rd_hit)        stall_st_ld <= stall_st_ld + CNT_W'(1);
        else if (wr_cls)             stall_st_st <= stall_st_st + CNT_W'(1);
        else if (wr_hit)             stall_ld_st <= stall_ld_st + CNT_W'(1);
        else                         stall_ld_ld <= stall_ld_ld + CNT_W'(1);
      end
    end
  end

  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    int'(outstanding) == int'(rd_occ) + int'(wr_occ)) else $error("count mismatch"); // R8
  AST_FULL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && int'(outstanding) >= MAX_OUT) |-> (rsp_status == ST_FULL)) else $error("limit ignored"); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(outstanding) <= MAX_OUT) else $error("count overflow"); // R2
  AST_ALIAS_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_status == ST_ALIAS) |=>
      (int'(stall_st_ld) + int'(stall_st_st) + int'(stall_ld_st) + int'(stall_ld_ld) ==
       int'($past(stall_st_ld)) + int'($past(stall_st_st)) + int'($past(stall_ld_st)) +
       int'($past(stall_ld_ld)) + 1)) else $error("alias not counted"); // R5
  AST_PROTO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err) else $error("proto flag dropped"); // R11
endmodule

// File: tb/line_req_tracker_test.sv
`timescale 1ns/1ps
module line_req_tracker_test;
  localparam int ADDR_W = 16;
  localparam int OUT_W  = $clog2(7 + 1);
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [3:0]        req_kind = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        rsp_status;
  logic              rd_done = 1'b0;
  logic [ADDR_W-1:0] rd_done_addr = '0;
  logic              wr_done = 1'b0;
  logic [ADDR_W-1:0] wr_done_addr = '0;
  logic [OUT_W-1:0]  outstanding;
  logic [CNT_W-1:0]  stall_st_ld, stall_st_st, stall_ld_st, stall_ld_ld;
  logic              deadlock, proto_err;

  int tests = 0;
  int fails = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  line_req_tracker #(
    .ADDR_W(ADDR_W), .LINE_BYTES(16), .RD_DEPTH(4), .WR_DEPTH(4),
    .MAX_OUT(7), .WDOG_CYC(200), .CNT_W(CNT_W)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .rsp_status(rsp_status), .rd_done(rd_done),
    .rd_done_addr(rd_done_addr), .wr_done(wr_done), .wr_done_addr(wr_done_addr),
    .outstanding(outstanding), .stall_st_ld(stall_st_ld), .stall_st_st(stall_st_st),
    .stall_ld_st(stall_ld_st), .stall_ld_ld(stall_ld_ld), .deadlock(deadlock),
    .proto_err(proto_err));

  // kind codes restated from R1
  localparam logic [3:0] LD = 4'd0, IF = 4'd1, ST = 4'd2, RMWW = 4'd4, LL = 4'd5,
                         SC = 4'd6, LKR = 4'd7, FL = 4'd9;
  localparam logic [1:0] S_NONE = 2'b00, S_ISS = 2'b01, S_ALI = 2'b10, S_FULL = 2'b11;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected status whenever a request is on the port
  always @(negedge clk) begin
    if (rst_n && req_valid) begin
      if (exp_q.size() == 0) chk("R6 unexpected request", 1, 0);
      else begin
        string t;
        logic [1:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, int'(rsp_status), int'(e));
      end
    end
  end

  task automatic step(input logic v, input logic [3:0] k, input logic [ADDR_W-1:0] a,
                      input logic [1:0] exp, input string t,
                      input logic rv, input logic [ADDR_W-1:0] ra,
                      input logic wv, input logic [ADDR_W-1:0] wa);
    @(posedge clk); #1;
    req_valid = v; req_kind = k; req_addr = a;
    rd_done = rv; rd_done_addr = ra; wr_done = wv; wr_done_addr = wa;
    if (v) begin exp_q.push_back(exp); tag_q.push_back(t); end
    @(posedge clk); #1;
    req_valid = 1'b0; rd_done = 1'b0; wr_done = 1'b0;
  endtask

  task automatic req(input logic [3:0] k, input logic [ADDR_W-1:0] a,
                     input logic [1:0] exp, input string t);
    step(1'b1, k, a, exp, t, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic rdone(input logic [ADDR_W-1:0] a);
    step(1'b0, '0, '0, S_NONE, "", 1'b1, a, 1'b0, '0);
  endtask

  task automatic wdone(input logic [ADDR_W-1:0] a);
    step(1'b0, '0, '0, S_NONE, "", 1'b0, '0, 1'b1, a);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cnts(input string t, input int a, input int b, input int c, input int d);
    @(negedge clk);
    chk({t, " stall_st_ld"}, int'(stall_st_ld), a);
    chk({t, " stall_st_st"}, int'(stall_st_st), b);
    chk({t, " stall_ld_st"}, int'(stall_ld_st), c);
    chk({t, " stall_ld_ld"}, int'(stall_ld_ld), d);
  endtask

  task automatic occ(input string t, input int e);
    @(negedge clk);
    chk(t, int'(outstanding), e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R6 reset status", int'(rsp_status), 0);
    chk("R8 reset outstanding", int'(outstanding), 0);
    chk("R9 reset deadlock", int'(deadlock), 0);
    chk("R11 reset proto_err", int'(proto_err), 0);
    cnts("R5 reset", 0, 0, 0, 0);

    req(LD, 16'h0100, S_ISS, "R6 load issued");
    req(IF, 16'h0200, S_ISS, "R6 ifetch issued");
    occ("R6 outstanding after two", 2);
    req(ST, 16'h0108, S_ALI, "R3 store on read line");
    cnts("R3", 1, 0, 0, 0);
    req(LD, 16'h010C, S_ALI, "R5 load on read line, offset differs");
    cnts("R5 ld_ld", 1, 0, 0, 1);
    req(ST, 16'h0300, S_ISS, "R6 store issued");
    req(FL, 16'h0304, S_ALI, "R4 flush on write line");
    cnts("R4", 1, 1, 0, 1);
    req(IF, 16'h0308, S_ALI, "R5 ifetch on write line");
    cnts("R5 ld_st", 1, 1, 1, 1);
    req(LL, 16'h0400, S_ISS, "R1 load-linked issued");
    req(LD, 16'h0400, S_ALI, "R1 load after LL is load-on-write");
    cnts("R1 LL write class", 1, 1, 2, 1);
    req(SC, 16'h0500, S_ISS, "R1 store-conditional issued");
    req(LKR, 16'h0600, S_ISS, "R1 locked read issued");
    occ("R6 outstanding six", 6);
    req(RMWW, 16'h0A00, S_FULL, "R12 write table full");
    occ("R12 outstanding unchanged", 6);
    req(LD, 16'h0900, S_ISS, "R6 load fills limit");
    occ("R2 outstanding at max", 7);
    req(LD, 16'h0100, S_FULL, "R2 full before alias lookup");
    cnts("R2 no counter change", 1, 1, 2, 1);

    wdone(16'h0300);
    occ("R7 write completion", 6);
    rdone(16'h0100);
    occ("R7 read completion", 5);
    req(LD, 16'h0104, S_ISS, "R7 freed line reissued");
    step(1'b1, LD, 16'h0700, S_ISS, "R8 issue with completion", 1'b1, 16'h0200, 1'b0, '0);
    occ("R8 same-cycle count", 6);
    rdone(16'h0400);
    @(negedge clk);
    chk("R11 stray completion flag", int'(proto_err), 1);
    occ("R11 no entry changed", 6);
    rdone(16'h0100); rdone(16'h0900); rdone(16'h0700);
    wdone(16'h0400); wdone(16'h0500); wdone(16'h0600);
    occ("R7 drained", 0);
    req(ST, 16'h0100, S_ISS, "R7 line reusable as write");
    wdone(16'h0100);
    @(negedge clk);
    chk("R10 no deadlock in quick traffic", int'(deadlock), 0);
    chk("R11 proto_err sticky", int'(proto_err), 1);

    // entry that never completes
    do_reset();
    req(LD, 16'h0100, S_ISS, "R9 aging load issued");
    idle(190);
    chk("R9 before threshold", int'(deadlock), 0);
    idle(20);
    chk("R9 deadlock raised", int'(deadlock), 1);

    // early completion, later entry caught by the rearmed period
    do_reset();
    req(LD, 16'h0100, S_ISS, "R10 first load issued");
    idle(148);
    step(1'b1, ST, 16'h0200, S_ISS, "R9 store with completion", 1'b1, 16'h0100, 1'b0, '0);
    idle(140);
    chk("R10 completed entry not flagged", int'(deadlock), 0);
    idle(130);
    chk("R9 rearmed period flags store", int'(deadlock), 1);

    // idle tracker
    do_reset();
    req(IF, 16'h0100, S_ISS, "R10 fetch issued");
    idle(10);
    rdone(16'h0100);
    idle(450);
    chk("R10 idle no deadlock", int'(deadlock), 0);
    chk("R8 idle outstanding", int'(outstanding), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule